// File: doc/BRIEF.md
# Motor Command Dispatcher

This block sits behind a frame parser on a motor controller. Each parsed frame has an 11-bit identifier, a byte count and up to eight payload bytes. The block decides whether the frame is a command for the motor it serves. If it is, the block updates the gain, target-speed and sampling-period registers and records which of the three setup commands have arrived. It also enables or disables the motor, selects between speed and position regulation, and emits the matching acknowledge identifier. A frame addressed anywhere else is copied to a forward output, so the surrounding system can relay it to the other board or to the host.

There is no explicit start command. The motor runs once the gains, derivative/speed and sampling-period commands have all been received, in any order. A stop command or a mode-change command halts the motor and discards the partial setup. A strap input, `is_motor_b`, chooses which of the two per-motor identifier sets the unit answers to.

Top module: `motor_cmd_dispatch`

## Requirements
- R1: After reset the motor is disabled, speed regulation is selected (`pos_mode`=0), `rx_mask` is 0, all parameter registers are 0, and neither `ack_valid` nor `fwd_valid` is asserted.
- R2: A frame is local when bits [10:3] of its identifier equal those of the unit's base (0x100 when `is_motor_b`=0, 0x200 when 1). Any other frame appears on the forward outputs on the clock edge after it is presented, with identical ID, length and data, and `fwd_valid` high for one cycle.
- R3: Local offset 0 with length 8 loads `kp` from payload bytes 0..3 (`in_data[63:32]`, byte 0 most significant) and `ki` from bytes 4..7 (`in_data[31:0]`), and sets `rx_mask` bit 0.
- R4: Local offset 1 with length 8 loads `kd` from `in_data[63:32]` and `rpm` from `in_data[31:0]`, and sets `rx_mask` bit 1.
- R5: Local offset 2 with length 4 loads `sample_ms` from `in_data[63:32]` and sets `rx_mask` bit 2.
- R6: When a setup command completes the mask (all three bits), `motor_en` becomes 1 and `rx_mask` returns to 0 on the same edge as the acknowledge.
- R7: Local offset 4 with length 0 (stop) clears `motor_en` and `rx_mask`.
- R8: Local offset 5 (length 0) and offset 6 (length 0) clear `motor_en` and `rx_mask`, and set `pos_mode` to 0 and to 1 respectively.
- R9: Each accepted command produces a one-cycle `ack_valid` on the following edge with `ack_id` for unit A / unit B: offset 0 -> 0x302/0x304, 1 -> 0x303/0x305, 2 -> 0x306/0x307, 4 -> 0x309/0x30B, 5 -> 0x30C/0x30D, 6 -> 0x30E/0x30F.
- R10: A local frame with offset 3 or 7, or with a length other than the one its command requires, is dropped: no acknowledge, no forward, and no change to any register, mask, enable or mode.
- R11: `ack_valid` and `fwd_valid` are never high together, and both stay low in a cycle that follows a clock edge with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_motor_b | input | 1 | Selects the unit's identifier set (0: 0x10x, 1: 0x20x) |
| in_valid | input | 1 | A parsed frame is present this cycle |
| in_id | input | 11 | Frame identifier |
| in_len | input | 4 | Payload byte count, 0..8 |
| in_data | input | 64 | Payload, byte 0 in bits [63:56] |
| kp | output | 32 | Proportional gain word |
| ki | output | 32 | Integral gain word |
| kd | output | 32 | Derivative gain word |
| rpm | output | 32 | Target speed |
| sample_ms | output | 32 | Speed sampling period |
| rx_mask | output | 3 | Setup commands received since last enable/stop |
| motor_en | output | 1 | Motor enabled |
| pos_mode | output | 1 | 1: position regulation, 0: speed regulation |
| ack_valid | output | 1 | Acknowledge pulse |
| ack_id | output | 11 | Acknowledge identifier (zero payload) |
| fwd_valid | output | 1 | Forwarded-frame pulse |
| fwd_id | output | 11 | Forwarded identifier |
| fwd_len | output | 4 | Forwarded length |
| fwd_data | output | 64 | Forwarded payload |

## Verification
The three setup commands are driven in order to show that the enable fires only on the last one. A stop arriving mid-setup shows that partial progress is discarded rather than carried over. Frames with offsets 3 and 7, and known offsets with wrong lengths, are sent to separate a dropped frame from a forwarded one, and the parameter and mask outputs show that nothing changed. The same sequences are repeated with the unit strapped as B, and the other unit's identifiers are sent to each unit, which separates the per-unit acknowledge tables and confirms that ownership follows the strap.

// File: rtl/motor_cmd_dispatch.sv
module motor_cmd_dispatch #(
  parameter int ID_W   = 11,
  parameter int LEN_W  = 4,
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  is_motor_b,
  input  logic                  in_valid,
  input  logic [ID_W-1:0]       in_id,
  input  logic [LEN_W-1:0]      in_len,
  input  logic [2*WORD_W-1:0]   in_data,
  output logic [WORD_W-1:0]     kp,
  output logic [WORD_W-1:0]     ki,
  output logic [WORD_W-1:0]     kd,
  output logic [WORD_W-1:0]     rpm,
  output logic [WORD_W-1:0]     sample_ms,
  output logic [2:0]            rx_mask,
  output logic                  motor_en,
  output logic                  pos_mode,
  output logic                  ack_valid,
  output logic [ID_W-1:0]       ack_id,
  output logic                  fwd_valid,
  output logic [ID_W-1:0]       fwd_id,
  output logic [LEN_W-1:0]      fwd_len,
  output logic [2*WORD_W-1:0]   fwd_data
);
  localparam int PAY_W = 2 * WORD_W;
  localparam logic [ID_W-1:0] BASE_A = ID_W'(11'h100);
  localparam logic [ID_W-1:0] BASE_B = ID_W'(11'h200);
  localparam logic [LEN_W-1:0] LEN_PAIR = LEN_W'(8);
  localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(4);
  localparam logic [LEN_W-1:0] LEN_NONE = LEN_W'(0);

  logic [ID_W-1:0]   base;
  logic              local_hit;
  logic [2:0]        ofs;
  logic              len_ok;
  logic              take;
  logic [2:0]        set_bit;
  logic [2:0]        mask_nx;
  logic              full;
  logic              halt;
  logic [ID_W-1:0]   ack_nx;
  logic [WORD_W-1:0] hi_word, lo_word;

  assign base      = is_motor_b ? BASE_B : BASE_A;
  assign local_hit = in_id[ID_W-1:3] == base[ID_W-1:3];
  assign ofs       = in_id[2:0];
  assign hi_word   = in_data[PAY_W-1:WORD_W];
  assign lo_word   = in_data[WORD_W-1:0];

  always_comb begin
    case (ofs)
      3'd0, 3'd1:       len_ok = in_len == LEN_PAIR;
      3'd2:             len_ok = in_len == LEN_ONE;
      3'd4, 3'd5, 3'd6: len_ok = in_len == LEN_NONE;
      default:          len_ok = 1'b0;
    endcase
  end

  assign take    = in_valid && local_hit && len_ok;
  assign set_bit = (ofs < 3'd3) ? (3'b001 << ofs) : 3'b000;
  assign mask_nx = rx_mask | set_bit;
  assign full    = &mask_nx;
  assign halt    = ofs[2];

  always_comb begin
    case ({is_motor_b, ofs})
      4'b0_000: ack_nx = ID_W'(11'h302);
      4'b0_001: ack_nx = ID_W'(11'h303);
      4'b0_010: ack_nx = ID_W'(11'h306);
      4'b0_100: ack_nx = ID_W'(11'h309);
      4'b0_101: ack_nx = ID_W'(11'h30C);
      4'b0_110: ack_nx = ID_W'(11'h30E);
      4'b1_000: ack_nx = ID_W'(11'h304);
      4'b1_001: ack_nx = ID_W'(11'h305);
      4'b1_010: ack_nx = ID_W'(11'h307);
      4'b1_100: ack_nx = ID_W'(11'h30B);
      4'b1_101: ack_nx = ID_W'(11'h30D);
      4'b1_110: ack_nx = ID_W'(11'h30F);
      default:  ack_nx = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kp        <= '0;
      ki        <= '0;
      kd        <= '0;
      rpm       <= '0;
      sample_ms <= '0;
      rx_mask   <= '0;
      motor_en  <= 1'b0;
      pos_mode  <= 1'b0;
    end else if (take) begin
      if (ofs == 3'd0) begin
        kp <= hi_word;
        ki <= lo_word;
      end
      if (ofs == 3'd1) begin
        kd  <= hi_word;
        rpm <= lo_word;
      end
      if (ofs == 3'd2) sample_ms <= hi_word;
      if (halt) begin
        rx_mask  <= '0;
        motor_en <= 1'b0;
        if (ofs == 3'd5) pos_mode <= 1'b0;
        if (ofs == 3'd6) pos_mode <= 1'b1;
      end else if (full) begin
        rx_mask  <= '0;
        motor_en <= 1'b1;
      end else begin
        rx_mask  <= mask_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack_id    <= '0;
      fwd_valid <= 1'b0;
      fwd_id    <= '0;
      fwd_len   <= '0;
      fwd_data  <= '0;
    end else begin
      ack_valid <= take;
      fwd_valid <= in_valid && !local_hit;
      if (take) ack_id <= ack_nx;
      if (in_valid && !local_hit) begin
        fwd_id   <= in_id;
        fwd_len  <= in_len;
        fwd_data <= in_data;
      end
    end
  end
endmodule

module motor_cmd_dispatch_chk #(
  parameter int ID_W   = 11,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] kp,
  input logic [2:0]        rx_mask,
  input logic              motor_en,
  input logic              ack_valid,
  input logic [ID_W-1:0]   ack_id,
  input logic              fwd_valid
);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_valid && fwd_valid));
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> (!ack_valid && !fwd_valid));
  a_r6_enable_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(motor_en) |-> (ack_valid && rx_mask == 3'b000));
  a_r6_mask_never_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mask != 3'b111);
  a_r7_disable_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(motor_en) |-> ack_valid);
  a_r9_ack_range: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (ack_id[ID_W-1:4] == 7'h30 && ack_id[3:0] >= 4'h2));
  a_r3_kp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_valid && (ack_id == 11'h302 || ack_id == 11'h304)) |-> $stable(kp));
endmodule

bind motor_cmd_dispatch motor_cmd_dispatch_chk #(.ID_W(ID_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .kp(kp), .rx_mask(rx_mask),
  .motor_en(motor_en), .ack_valid(ack_valid), .ack_id(ack_id), .fwd_valid(fwd_valid)
);

// File: tb/motor_cmd_dispatch_bench.sv
module motor_cmd_dispatch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        is_motor_b = 1'b0;
  logic        in_valid = 1'b0;
  logic [10:0] in_id = '0;
  logic [3:0]  in_len = '0;
  logic [63:0] in_data = '0;
  logic [31:0] kp, ki, kd, rpm, sample_ms;
  logic [2:0]  rx_mask;
  logic        motor_en, pos_mode, ack_valid, fwd_valid;
  logic [10:0] ack_id, fwd_id;
  logic [3:0]  fwd_len;
  logic [63:0] fwd_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  motor_cmd_dispatch u_motor_cmd_dispatch (
    .clk(clk), .rst_n(rst_n), .is_motor_b(is_motor_b), .in_valid(in_valid),
    .in_id(in_id), .in_len(in_len), .in_data(in_data), .kp(kp), .ki(ki),
    .kd(kd), .rpm(rpm), .sample_ms(sample_ms), .rx_mask(rx_mask),
    .motor_en(motor_en), .pos_mode(pos_mode), .ack_valid(ack_valid),
    .ack_id(ack_id), .fwd_valid(fwd_valid), .fwd_id(fwd_id),
    .fwd_len(fwd_len), .fwd_data(fwd_data)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(bit unit_b);
    @(negedge clk);
    rst_n = 1'b0;
    is_motor_b = unit_b;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(logic [10:0] id, logic [3:0] len, logic [63:0] data);
    @(negedge clk);
    in_valid = 1'b1;
    in_id = id;
    in_len = len;
    in_data = data;
    @(negedge clk);
    in_valid = 1'b0;
    in_data = '0;
  endtask

  task automatic expect_ack(string tag, logic [10:0] id);
    chk({tag, " ack_valid"}, 64'(ack_valid), 64'd1);
    chk({tag, " ack_id"}, 64'(ack_id), 64'(id));
    chk({tag, " fwd_valid"}, 64'(fwd_valid), 64'd0);
  endtask

  task automatic expect_silent(string tag);
    chk({tag, " ack_valid"}, 64'(ack_valid), 64'd0);
    chk({tag, " fwd_valid"}, 64'(fwd_valid), 64'd0);
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R1 motor_en", 64'(motor_en), 64'd0);
    chk("R1 pos_mode", 64'(pos_mode), 64'd0);
    chk("R1 rx_mask", 64'(rx_mask), 64'd0);
    chk("R1 kp", 64'(kp), 64'd0);
    chk("R1 sample_ms", 64'(sample_ms), 64'd0);
    expect_silent("R1");
  endtask

  task automatic t_setup_a();
    send(11'h100, 4'd8, 64'h11223344_55667788);
    expect_ack("R9 gains A", 11'h302);
    chk("R3 kp", 64'(kp), 64'h11223344);
    chk("R3 ki", 64'(ki), 64'h55667788);
    chk("R3 mask", 64'(rx_mask), 64'd1);
    chk("R6 not yet", 64'(motor_en), 64'd0);
    @(negedge clk);
    chk("R9 ack one cycle", 64'(ack_valid), 64'd0);
    send(11'h101, 4'd8, 64'hA0A1A2A3_000005DC);
    expect_ack("R9 deriv A", 11'h303);
    chk("R4 kd", 64'(kd), 64'hA0A1A2A3);
    chk("R4 rpm", 64'(rpm), 64'h5DC);
    chk("R4 mask", 64'(rx_mask), 64'd3);
    send(11'h102, 4'd4, 64'h0000000A_DEADBEEF);
    expect_ack("R9 sample A", 11'h306);
    chk("R5 sample_ms", 64'(sample_ms), 64'hA);
    chk("R6 motor_en", 64'(motor_en), 64'd1);
    chk("R6 mask cleared", 64'(rx_mask), 64'd0);
  endtask

  task automatic t_stop();
    send(11'h104, 4'd0, '0);
    expect_ack("R9 stop A", 11'h309);
    chk("R7 motor_en", 64'(motor_en), 64'd0);
    send(11'h102, 4'd4, 64'h00000014_00000000);
    send(11'h100, 4'd8, 64'h1_00000002);
    chk("R7 partial mask", 64'(rx_mask), 64'd5);
    send(11'h104, 4'd0, '0);
    chk("R7 mask cleared", 64'(rx_mask), 64'd0);
    send(11'h101, 4'd8, 64'h3_00000004);
    chk("R7 no carry-over", 64'(motor_en), 64'd0);
    chk("R7 mask restart", 64'(rx_mask), 64'd2);
  endtask

  task automatic t_dropped();
    logic [31:0] kp0 = kp;
    logic [31:0] sm0 = sample_ms;
    logic [2:0]  m0 = rx_mask;
    send(11'h103, 4'd0, '0);
    expect_silent("R10 ofs3");
    send(11'h107, 4'd0, '0);
    expect_silent("R10 ofs7");
    send(11'h100, 4'd4, 64'hFFFFFFFF_FFFFFFFF);
    expect_silent("R10 short gains");
    chk("R10 kp kept", 64'(kp), 64'(kp0));
    send(11'h102, 4'd8, 64'hFFFFFFFF_FFFFFFFF);
    expect_silent("R10 long sample");
    chk("R10 sample kept", 64'(sample_ms), 64'(sm0));
    send(11'h104, 4'd1, 64'h0);
    expect_silent("R10 stop with data");
    chk("R10 mask kept", 64'(rx_mask), 64'(m0));
    send(11'h106, 4'd2, 64'h0);
    chk("R10 mode kept", 64'(pos_mode), 64'd0);
  endtask

  task automatic t_forward();
    logic [31:0] kd0 = kd;
    send(11'h201, 4'd8, 64'h0102030405060708);
    chk("R2 fwd_valid", 64'(fwd_valid), 64'd1);
    chk("R2 fwd_id", 64'(fwd_id), 64'h201);
    chk("R2 fwd_len", 64'(fwd_len), 64'd8);
    chk("R2 fwd_data", fwd_data, 64'h0102030405060708);
    chk("R11 no ack on fwd", 64'(ack_valid), 64'd0);
    chk("R2 kd kept", 64'(kd), 64'(kd0));
    @(negedge clk);
    chk("R11 fwd one cycle", 64'(fwd_valid), 64'd0);
    send(11'h302, 4'd0, '0);
    chk("R2 ack id forwarded", 64'(fwd_id), 64'h302);
    chk("R2 fwd_valid 2", 64'(fwd_valid), 64'd1);
  endtask

  task automatic t_modes_a();
    send(11'h100, 4'd8, 64'h5);
    send(11'h106, 4'd0, '0);
    expect_ack("R9 pos A", 11'h30E);
    chk("R8 pos_mode", 64'(pos_mode), 64'd1);
    chk("R8 mask", 64'(rx_mask), 64'd0);
    send(11'h100, 4'd8, 64'h5);
    send(11'h101, 4'd8, 64'h6);
    send(11'h102, 4'd4, 64'h7_00000000);
    chk("R6 enable in pos mode", 64'(motor_en), 64'd1);
    send(11'h105, 4'd0, '0);
    expect_ack("R9 speed A", 11'h30C);
    chk("R8 speed mode", 64'(pos_mode), 64'd0);
    chk("R8 disabled", 64'(motor_en), 64'd0);
  endtask

  task automatic t_unit_b();
    do_reset(1'b1);
    send(11'h202, 4'd4, 64'h00000064_00000000);
    expect_ack("R9 sample B", 11'h307);
    send(11'h201, 4'd8, 64'h7_00000008);
    expect_ack("R9 deriv B", 11'h305);
    send(11'h200, 4'd8, 64'h9_0000000A);
    expect_ack("R9 gains B", 11'h304);
    chk("R6 B enabled", 64'(motor_en), 64'd1);
    chk("R5 B sample", 64'(sample_ms), 64'h64);
    send(11'h204, 4'd0, '0);
    expect_ack("R9 stop B", 11'h30B);
    send(11'h206, 4'd0, '0);
    expect_ack("R9 pos B", 11'h30F);
    send(11'h205, 4'd0, '0);
    expect_ack("R9 speed B", 11'h30D);
    send(11'h100, 4'd8, 64'h1);
    chk("R2 B forwards A id", 64'(fwd_valid), 64'd1);
    chk("R2 B kp untouched", 64'(kp), 64'h9);
  endtask

  initial begin
    t_reset();
    t_setup_a();
    t_stop();
    t_dropped();
    t_forward();
    t_modes_a();
    t_unit_b();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule